// File: doc/BRIEF.md
# Banked Test-Register Window

This block sits behind a PHY-style management register bus with 5-bit register addresses and 16-bit data. Three directly addressed registers form a window into hidden banks of test registers. The directly addressed registers are a control word, a read-data register and a staged write-data register. The hidden banks are analog/DSP, wake-on-LAN and built-in self-test. Bank 1 holds a status bit at register 0xC bit 12. Bank 3 holds PLL control and divider settings at 0x1B to 0x1D. In this block all of these are plain 16-bit storage locations.

The banks are sealed after reset. The host opens them with a fixed four-write sequence on the control word. It then issues indirect commands, each naming a bank and a register inside the same control write. A write command commits the staged write data to the addressed register. A read command copies the addressed register into the read-data register. A control write with the test-mode bit clear seals the banks again.

Top module: `tbank_access`

## Requirements
- R1: Address 20 reads back the last control word written, address 23 reads back the staged write data, and address 21 reads the read-data register. Every other address reads 0. Reads are combinational, and bus writes to address 21 change nothing.
- R2: The banks open only after four consecutive control writes of 0x0000, 0x0400, 0x0000 and 0x0400. Bit 10 is the test-mode bit.
- R3: While the banks are sealed, any control write other than the next expected value returns the sequence to its start, so the full four writes are needed again.
- R4: While the banks are open, a control word with bit 14 and bit 10 set writes the staged data into bank bits 12:11 at register bits 4:0.
- R5: While the banks are open, a control word with bit 15 and bit 10 set, and bit 14 clear, loads bank bits 12:11 at register bits 9:5 into the read-data register on that clock edge.
- R6: While the banks are open, any control write with bit 10 clear (0 included) seals the banks without executing a command. Reopening needs the full four-write sequence.
- R7: While the banks are sealed, write commands change no bank register, and a control write with bit 15 set clears the read-data register to 0.
- R8: With bits 15 and 14 both set in one open command, only the write happens and the read-data register keeps its value.
- R9: Banks 0, 1 and 3 are implemented. Bank 2 reads as 0, and writes to it are dropped.
- R10: A synchronous active-high reset clears the control word, the staged data, the read-data register, the sequence tracker and every bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Direct register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data of the addressed register |

## Verification
Directed sequences cover these cases:
- A clean open followed by writes and reads in each bank, which shows that bank select and both address fields are decoded separately.
- An unlock broken by a stray value, which separates a tracker that restarts from one that skips the bad write.
- Commands sent after a seal, and a combined read/write word, which separate command gating and write priority.

Constrained random traffic from a fixed seed mixes unlock sequences, staged data, random control words and stray bus writes. Its results are compared after every operation against a bench model of the banks. This exposes errors in ordering and field overlap that the directed cases do not reach.

// File: rtl/tbank_access.sv
module tbank_access #(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 20,
  parameter int RDAT_ADDR = 21,
  parameter int WDAT_ADDR = 23,
  parameter int BANK_BITS = 2,
  parameter logic [3:0] IMPL_MASK = 4'b1011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int NBANK     = 1 << BANK_BITS;
  localparam int NREG      = 1 << AW;
  localparam int RD_BIT    = 15;
  localparam int WR_BIT    = 14;
  localparam int BANK_LSB  = 11;
  localparam int TM_BIT    = 10;
  localparam int RADDR_LSB = 5;
  localparam logic [DW-1:0] TM_WORD = DW'(1) << TM_BIT;

  typedef enum logic [2:0] {LK_IDLE, LK_Z1, LK_T1, LK_Z2, LK_OPEN} lk_t;

  lk_t st_q, st_d;
  logic [DW-1:0] ctrl_q, wd_q, rd_q;
  logic [DW-1:0] bank_rd [NBANK];

  wire ctrl_wr = bus_we && (bus_addr == AW'(CTRL_ADDR));
  wire wdat_wr = bus_we && (bus_addr == AW'(WDAT_ADDR));
  wire is_open = (st_q == LK_OPEN);
  wire tm      = bus_wdata[TM_BIT];
  wire [BANK_BITS-1:0] sel   = bus_wdata[BANK_LSB +: BANK_BITS];
  wire [AW-1:0]        raddr = bus_wdata[RADDR_LSB +: AW];
  wire [AW-1:0]        waddr = bus_wdata[AW-1:0];
  wire do_wr = ctrl_wr && is_open && tm && bus_wdata[WR_BIT];
  wire do_rd = ctrl_wr && is_open && tm && bus_wdata[RD_BIT] && !bus_wdata[WR_BIT];
  wire lk_rd = ctrl_wr && !is_open && bus_wdata[RD_BIT];

  always_comb begin
    st_d = st_q;
    if (ctrl_wr) begin
      unique case (st_q)
        LK_IDLE: st_d = (bus_wdata == '0)      ? LK_Z1   : LK_IDLE;
        LK_Z1:   st_d = (bus_wdata == TM_WORD) ? LK_T1   : LK_IDLE;
        LK_T1:   st_d = (bus_wdata == '0)      ? LK_Z2   : LK_IDLE;
        LK_Z2:   st_d = (bus_wdata == TM_WORD) ? LK_OPEN : LK_IDLE;
        LK_OPEN: st_d = tm ? LK_OPEN : LK_IDLE;
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LK_IDLE;
      ctrl_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      st_q <= st_d;
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (wdat_wr) wd_q <= bus_wdata;
      if (do_rd) rd_q <= bank_rd[sel];
      else if (lk_rd) rd_q <= '0;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (IMPL_MASK[b]) begin : g_impl
      logic [DW-1:0] regs [NREG];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (do_wr && sel == BANK_BITS'(b)) begin
          regs[waddr] <= wd_q;
        end
      end
      assign bank_rd[b] = regs[raddr];
    end else begin : g_hole
      assign bank_rd[b] = '0;
    end
  end

  always_comb begin
    if (bus_addr == AW'(CTRL_ADDR))      bus_rdata = ctrl_q;
    else if (bus_addr == AW'(RDAT_ADDR)) bus_rdata = rd_q;
    else if (bus_addr == AW'(WDAT_ADDR)) bus_rdata = wd_q;
    else                                 bus_rdata = '0;
  end

  AST_OPEN_AFTER_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> $past(st_q == LK_Z2)); // R2
  AST_CLOSE_ON_TM_CLR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !tm) |=> !is_open); // R6
  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    lk_rd |=> (rd_q == '0)); // R7
  AST_BOTH_KEEP_RDATA: assert property (@(posedge clk) disable iff (rst)
    (do_wr && bus_wdata[RD_BIT]) |=> $stable(rd_q)); // R8
  AST_WDATA_STAGED: assert property (@(posedge clk) disable iff (rst)
    wdat_wr |=> (bus_rdata == wd_q || bus_addr != AW'(WDAT_ADDR)) && (wd_q == $past(bus_wdata))); // R1
endmodule

// File: tb/tbank_access_test.sv
module tbank_access_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] bm [4][32];
  int st_m;
  logic [15:0] ctrl_m, wd_m, rd_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbank_access uut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [15:0] exp_read(logic [4:0] a);
    case (a)
      5'd20: return ctrl_m;
      5'd21: return rd_m;
      5'd23: return wd_m;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] cmd(bit r, bit w, logic [1:0] bank, bit t,
                                      logic [4:0] ra, logic [4:0] wa);
    return {r, w, 1'b0, bank, t, ra, wa};
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 4; b++) for (int i = 0; i < 32; i++) bm[b][i] = 16'h0;
    st_m = 0; ctrl_m = 0; wd_m = 0; rd_m = 0;
  endtask

  task automatic model_ctrl(logic [15:0] d);
    logic [1:0] bk;
    logic [15:0] nxt;
    bk = d[12:11];
    ctrl_m = d;
    if (st_m == 4) begin
      if (!d[10]) st_m = 0;
      else if (d[14]) begin
        if (bk != 2'd2) bm[bk][d[4:0]] = wd_m;
      end else if (d[15]) rd_m = (bk == 2'd2) ? 16'h0 : bm[bk][d[9:5]];
    end else begin
      if (d[15]) rd_m = 16'h0;
      nxt = (st_m == 0 || st_m == 2) ? 16'h0000 : 16'h0400;
      st_m = (d == nxt) ? st_m + 1 : 0;
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
    if (a == 5'd20) model_ctrl(d);
    else if (a == 5'd23) wd_m = d;
  endtask

  task automatic check(logic [4:0] a, string tag);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    e = exp_read(a);
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic unlock();
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
  endtask

  task automatic ind_read(logic [1:0] bk, logic [4:0] ra, string tag);
    wr(20, cmd(1, 0, bk, 1, ra, 0));
    check(21, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R10 reset state
    check(20, "R10"); check(21, "R10"); check(23, "R10"); check(7, "R1");
    unlock();
    ind_read(0, 5, "R10");
    ind_read(3, 5'h1B, "R10");

    // R4 R5 R2 write then read bank 3
    wr(23, 16'h0005);
    wr(20, cmd(0, 1, 3, 1, 0, 5'h1B));
    wr(23, 16'h029A);
    wr(20, cmd(0, 1, 3, 1, 0, 5'h1D));
    ind_read(3, 5'h1B, "R5");
    ind_read(3, 5'h1D, "R4");
    check(20, "R1"); check(23, "R1");
    wr(21, 16'hFFFF); check(21, "R1");
    ind_read(0, 5'h1D, "R4");

    // R8 combined read+write
    wr(23, 16'hBEEF);
    wr(20, cmd(1, 1, 3, 1, 5'h1B, 5'h1C));
    check(21, "R8");
    ind_read(3, 5'h1C, "R8");

    // R9 bank 2
    wr(20, cmd(0, 1, 2, 1, 0, 5'h03));
    ind_read(2, 5'h03, "R9");
    wr(23, 16'h1000);
    wr(20, cmd(0, 1, 1, 1, 0, 5'h0C));
    ind_read(1, 5'h0C, "R9");

    // R6 close by TM clear with write bit
    wr(23, 16'h7777);
    wr(20, cmd(0, 1, 3, 0, 0, 5'h1B));
    wr(20, 16'h0400);
    ind_read(3, 5'h1B, "R6");
    // R7 sealed commands
    wr(20, 16'h0000);
    wr(20, cmd(0, 1, 3, 1, 0, 5'h1B));
    // R3 broken sequence
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0401);
    wr(20, 16'h0000); wr(20, 16'h0400);
    wr(20, cmd(0, 1, 1, 1, 0, 5'h0C));
    ind_read(1, 5'h0C, "R3");
    unlock();
    ind_read(3, 5'h1B, "R7");
    ind_read(1, 5'h0C, "R3");

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 2000; n++) begin
      int r;
      logic [4:0] a;
      r = $urandom % 10;
      a = ($urandom % 2) ? 5'($urandom % 8) : 5'($urandom % 32);
      case (r)
        0, 1: unlock();
        2, 3: wr(23, 16'($urandom));
        4, 5, 6, 7: wr(20, cmd(1'($urandom), 1'($urandom), 2'($urandom),
                                ($urandom % 5) != 0, a, 5'($urandom % 8)));
        8: wr(5'($urandom), 16'($urandom));
        default: check(5'($urandom), "R1");
      endcase
      check(21, "R5");
      if (n % 4 == 0) check(20, "R1");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule